// File: doc/BRIEF.md
# Time-Proportional Dual Heater Controller

This block decides, once per sensor reading, whether to warm a humidity heater, an air heater, or neither. It then drives the chosen heater with a slow on/off pattern counted in whole seconds. A sequencer outside the block presents a reading with a one-cycle valid strobe, together with an error flag. The block raises `busy` while it works through the resulting heating cycle or wait. When `busy` falls, the sequencer may fetch and present the next reading.

Humidity has priority: the humidity heater runs whenever humidity is under its goal. The air heater runs only when humidity is satisfied and temperature is under its goal. The two heaters use different cycle lengths and derive their on-time from the 8-bit rate in different ways. A failed reading keeps both heaters off for a short retry wait. A reading that needs no heating produces a longer idle wait. A clock divider, set by a parameter, supplies the one-second timebase, so a bench can use a short second.

Top module: `heat_duty_ctrl`

## Requirements
- R1: After reset, `heat_hum` and `heat_air` are 0 and `busy` is 0.
- R2: A valid, error-free reading whose humidity is below `hum_goal` (signed 8-bit compare) starts a humidity cycle. This applies whatever the temperature is.
- R3: A valid, error-free reading with humidity at or above `hum_goal` and temperature below `temp_goal` (signed compare) starts an air cycle.
- R4: A valid, error-free reading with neither quantity below its goal keeps both heaters off and holds `busy` high for 5 seconds.
- R5: A humidity cycle lasts 16 seconds. `heat_hum` is high for the first min(rate>>4, 16) seconds and low for the rest.
- R6: An air cycle lasts 32 seconds. `heat_air` is high for the first min(rate>>2, 32) seconds and low for the rest. Rates of 128 and above therefore give a heater that stays on for the whole cycle.
- R7: A reading with `rd_error` = 1 keeps both heaters off and holds `busy` high for 1 second, whatever the humidity and temperature values are.
- R8: `heat_hum` and `heat_air` are never high in the same cycle.
- R9: The decision and the rate are captured at acceptance. While `busy` is high, strobes, readings, goals and rate changes have no effect on the running cycle.
- R10: A strobe is accepted only while `busy` is low, and `busy` goes high in the next cycle. While `busy` is low, both heaters are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | One-cycle strobe presenting a reading |
| rd_error | input | 1 | Reading failed; retry after the short wait |
| rd_hum | input | 8 | Measured humidity, signed percent |
| rd_temp | input | 8 | Measured temperature, signed degrees |
| hum_goal | input | 8 | Humidity target, signed (80 nominal) |
| temp_goal | input | 8 | Temperature target, signed (30 nominal) |
| rate | input | 8 | Power rate, unsigned (128 nominal) |
| heat_hum | output | 1 | Humidity heater enable |
| heat_air | output | 1 | Air heater enable |
| busy | output | 1 | High while a cycle or wait is running |

## Verification
Two things can coincide. A new strobe can arrive while a cycle is running, and the rate and the readings can change during that same stretch. The bench fires an error strobe with rate 0 a few cycles into a humidity cycle. It then expects the exact on-time and length of the original decision, with no early end. A reading that is both an error and below both goals is also presented. The bench judges it by requiring no heater activity and a one-second `busy` window, so the error wins over the heating priority.

// File: rtl/heat_pkg.sv
// Shared types and nominal values for the dual heater controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package heat_pkg;

    // What a running cycle is doing.
    typedef enum logic [1:0] {
        PLAN_IDLE = 2'd0,   // no heating needed, long wait
        PLAN_HUM  = 2'd1,   // humidity heater cycle
        PLAN_AIR  = 2'd2,   // air heater cycle
        PLAN_ERR  = 2'd3    // bad reading, short wait
    } plan_e;

    // Sequencer state.
    typedef enum logic {
        ST_READY = 1'b0,
        ST_RUN   = 1'b1
    } state_e;

    // Nominal operating values for the inputs.
    localparam int NOM_HUM_GOAL  = 80;
    localparam int NOM_TEMP_GOAL = 30;
    localparam int NOM_RATE      = 128;

endpackage

// File: rtl/sec_timebase.sv
// Seconds timebase: a divider that pulses sec_tick once every
// TICKS_PER_SEC clocks. A restart pulse realigns the count so the next
// tick lands exactly one full second after the restart edge.
// Assumes: TICKS_PER_SEC >= 2.
module sec_timebase #(
    parameter int TICKS_PER_SEC = 8_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic sec_tick
);

    localparam int TW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICKS_PER_SEC - 1);

    logic [TW-1:0] cnt_q;

    assign sec_tick = (cnt_q == LAST);

    // Count clocks within the current second; restart or wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || sec_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: the count never passes the last tick value of a second.
    a_r5_divider_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R5: after a restart, no tick in the very next cycle.
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sec_tick);

endmodule

// File: rtl/chan_select.sv
// Decision logic: from one reading, pick the plan for the next cycle
// and work out its on-time and total length in seconds.
// Priority: error, then humidity below goal, then temperature below
// goal, else idle. Compares are signed. On-time saturates at the
// cycle length. Assumes: all lengths >= 1 and fit in SEC_W bits.
module chan_select
    import heat_pkg::*;
#(
    parameter int LEN_HUM   = 16,
    parameter int LEN_AIR   = 32,
    parameter int SHIFT_HUM = 4,
    parameter int SHIFT_AIR = 2,
    parameter int IDLE_SEC  = 5,
    parameter int ERR_SEC   = 1,
    parameter int SEC_W     = 6
) (
    input  logic              err,
    input  logic signed [7:0] hum,
    input  logic signed [7:0] temp,
    input  logic signed [7:0] hum_goal,
    input  logic signed [7:0] temp_goal,
    input  logic        [7:0] rate,
    output plan_e             plan,
    output logic [SEC_W-1:0]  on_sec,
    output logic [SEC_W-1:0]  len_sec
);

    logic [7:0]       raw_hum, raw_air;
    logic [SEC_W-1:0] on_hum, on_air;
    logic             hum_low, temp_low;

    // Scale the rate into each channel's seconds of on-time.
    always_comb begin
        raw_hum = rate >> SHIFT_HUM;
        raw_air = rate >> SHIFT_AIR;
        on_hum  = (32'(raw_hum) >= LEN_HUM) ? SEC_W'(LEN_HUM) : SEC_W'(raw_hum);
        on_air  = (32'(raw_air) >= LEN_AIR) ? SEC_W'(LEN_AIR) : SEC_W'(raw_air);
    end

    // Signed comparisons against the targets.
    always_comb begin
        hum_low  = (hum  < hum_goal);
        temp_low = (temp < temp_goal);
    end

    // Priority choice of plan, on-time and length.
    always_comb begin
        if (err) begin
            plan    = PLAN_ERR;
            on_sec  = '0;
            len_sec = SEC_W'(ERR_SEC);
        end else if (hum_low) begin
            plan    = PLAN_HUM;
            on_sec  = on_hum;
            len_sec = SEC_W'(LEN_HUM);
        end else if (temp_low) begin
            plan    = PLAN_AIR;
            on_sec  = on_air;
            len_sec = SEC_W'(LEN_AIR);
        end else begin
            plan    = PLAN_IDLE;
            on_sec  = '0;
            len_sec = SEC_W'(IDLE_SEC);
        end
    end

    // R5/R6: the chosen on-time never exceeds the chosen length.
    a_r6_on_within_len: assert final (on_sec <= len_sec);

endmodule

// File: rtl/duty_sequencer.sv
// Cycle sequencer: accepts a reading while ready, latches the plan,
// on-time and length, then counts whole seconds. Each heater is high
// for the first on_q seconds of its own plan. Returns to ready after
// len_q seconds. Assumes: sec_tick comes from a timebase restarted by
// the 'restart' output.
module duty_sequencer
    import heat_pkg::*;
#(
    parameter int SEC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_valid,
    input  logic             sec_tick,
    input  plan_e            plan_in,
    input  logic [SEC_W-1:0] on_in,
    input  logic [SEC_W-1:0] len_in,
    output logic             restart,
    output logic             busy,
    output logic             heat_hum,
    output logic             heat_air
);

    state_e           state_q;
    plan_e            plan_q;
    logic [SEC_W-1:0] on_q, len_q, sec_q;
    logic             accept, heat_phase;

    assign accept  = (state_q == ST_READY) && rd_valid;
    assign restart = accept;
    assign busy    = (state_q == ST_RUN);

    // Heater phase: running and still inside the on-seconds.
    always_comb begin
        heat_phase = busy && (sec_q < on_q);
        heat_hum   = heat_phase && (plan_q == PLAN_HUM);
        heat_air   = heat_phase && (plan_q == PLAN_AIR);
    end

    // State, latched decision and seconds counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            plan_q  <= PLAN_IDLE;
            on_q    <= '0;
            len_q   <= '0;
            sec_q   <= '0;
        end else if (accept) begin
            state_q <= ST_RUN;
            plan_q  <= plan_in;
            on_q    <= on_in;
            len_q   <= len_in;
            sec_q   <= '0;
        end else if (busy && sec_tick) begin
            if (sec_q == len_q - 1'b1) begin
                state_q <= ST_READY;
                sec_q   <= '0;
            end else begin
                sec_q   <= sec_q + 1'b1;
            end
        end
    end

    // R10: an accepted strobe makes busy high next cycle.
    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R9: the latched decision holds for the whole running cycle.
    a_r9_plan_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(plan_q) && $stable(on_q) && $stable(len_q)));

    // R5: a heater only switches on at the start of a cycle.
    a_r5_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(heat_hum) || $rose(heat_air)) |-> !$past(busy));

    // R7: an accepted error reading leaves both heaters off.
    a_r7_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && plan_in == PLAN_ERR) |=> (!heat_hum && !heat_air));

    // R9: the seconds counter stays below the latched length.
    a_r9_sec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sec_q < len_q));

endmodule

// File: rtl/heat_duty_ctrl.sv
// Top of the dual heater controller. It wires the decision logic, the
// seconds timebase and the cycle sequencer together. One reading gives
// one humidity cycle, one air cycle, an idle wait or an error wait.
// Assumes: rd_valid is sampled only while busy is low.
module heat_duty_ctrl
    import heat_pkg::*;
#(
    parameter int TICKS_PER_SEC = 8_000_000,
    parameter int LEN_HUM       = 16,
    parameter int LEN_AIR       = 32,
    parameter int SHIFT_HUM     = 4,
    parameter int SHIFT_AIR     = 2,
    parameter int IDLE_SEC      = 5,
    parameter int ERR_SEC       = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic              rd_error,
    input  logic signed [7:0] rd_hum,
    input  logic signed [7:0] rd_temp,
    input  logic signed [7:0] hum_goal,
    input  logic signed [7:0] temp_goal,
    input  logic        [7:0] rate,
    output logic              heat_hum,
    output logic              heat_air,
    output logic              busy
);

    localparam int MAX_A = (LEN_HUM > LEN_AIR) ? LEN_HUM : LEN_AIR;
    localparam int MAX_B = (IDLE_SEC > ERR_SEC) ? IDLE_SEC : ERR_SEC;
    localparam int MAX_S = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int SEC_W = $clog2(MAX_S + 1);

    plan_e            plan_w;
    logic [SEC_W-1:0] on_w, len_w;
    logic             restart_w, tick_w;

    chan_select #(
        .LEN_HUM   (LEN_HUM),
        .LEN_AIR   (LEN_AIR),
        .SHIFT_HUM (SHIFT_HUM),
        .SHIFT_AIR (SHIFT_AIR),
        .IDLE_SEC  (IDLE_SEC),
        .ERR_SEC   (ERR_SEC),
        .SEC_W     (SEC_W)
    ) u_select (
        .err       (rd_error),
        .hum       (rd_hum),
        .temp      (rd_temp),
        .hum_goal  (hum_goal),
        .temp_goal (temp_goal),
        .rate      (rate),
        .plan      (plan_w),
        .on_sec    (on_w),
        .len_sec   (len_w)
    );

    sec_timebase #(
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart_w),
        .sec_tick (tick_w)
    );

    duty_sequencer #(
        .SEC_W (SEC_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_valid (rd_valid),
        .sec_tick (tick_w),
        .plan_in  (plan_w),
        .on_in    (on_w),
        .len_in   (len_w),
        .restart  (restart_w),
        .busy     (busy),
        .heat_hum (heat_hum),
        .heat_air (heat_air)
    );

    // R8: the two heater enables are never high together.
    a_r8_one_heater: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({heat_hum, heat_air}));

    // R10: no heating while the block is ready for a reading.
    a_r10_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!heat_hum && !heat_air));

    // R1: one cycle after reset, everything is off.
    a_r1_reset_off: assert property (@(posedge clk)
        !$past(rst_n) |-> (!busy && !heat_hum && !heat_air));

endmodule

// File: tb/heat_duty_ctrl_test.sv
// Directed bench: each task presents one reading and measures the
// resulting busy window and heater on-time, in clock cycles.
module heat_duty_ctrl_test;

    localparam int TPS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_valid = 1'b0;
    logic              rd_error = 1'b0;
    logic signed [7:0] rd_hum = 8'sd0;
    logic signed [7:0] rd_temp = 8'sd0;
    logic signed [7:0] hum_goal = 8'sd80;
    logic signed [7:0] temp_goal = 8'sd30;
    logic        [7:0] rate = 8'd128;
    logic              heat_hum, heat_air, busy;

    int checks = 0;
    int fails  = 0;

    heat_duty_ctrl #(.TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_error(rd_error),
        .rd_hum(rd_hum), .rd_temp(rd_temp), .hum_goal(hum_goal),
        .temp_goal(temp_goal), .rate(rate), .heat_hum(heat_hum),
        .heat_air(heat_air), .busy(busy)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Present one reading and measure the cycle it starts.
    // chan: 0 none, 1 humidity, 2 air. on_s/len_s in seconds.
    task automatic run_case(input string tag, input int hum, input int temp,
                            input bit err, input int rt, input int chan,
                            input int on_s, input int len_s, input bit disturb);
        int n_busy = 0, n_hum = 0, n_air = 0, n_both = 0, n_late = 0;
        bit was_off = 1'b0;
        @(negedge clk);
        rd_hum = 8'(hum); rd_temp = 8'(temp); rd_error = err; rate = 8'(rt);
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        check({tag, " R10 busy after strobe"}, int'(busy), 1);
        for (int k = 0; k < 400 && busy; k++) begin
            n_busy++;
            if (heat_hum) n_hum++;
            if (heat_air) n_air++;
            if (heat_hum && heat_air) n_both++;
            if ((heat_hum || heat_air) && was_off) n_late++;
            if (!(heat_hum || heat_air)) was_off = 1'b1;
            if (disturb && k == 3) begin
                rd_valid = 1'b1; rd_error = 1'b1; rate = 8'd0;
                rd_hum = 8'sd100; hum_goal = 8'sd0;
            end
            if (disturb && k == 4) begin
                rd_valid = 1'b0; rd_error = 1'b0; hum_goal = 8'sd80;
            end
            @(negedge clk);
        end
        check({tag, " busy cycles"}, n_busy, len_s * TPS);
        check({tag, " hum heater cycles"}, n_hum, (chan == 1) ? on_s * TPS : 0);
        check({tag, " air heater cycles"}, n_air, (chan == 2) ? on_s * TPS : 0);
        check({tag, " R8 both heaters"}, n_both, 0);
        check({tag, " on-time contiguous"}, n_late, 0);
        check({tag, " R10 quiet when ready"}, int'(heat_hum || heat_air), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 heat_hum after reset", int'(heat_hum), 0);
        check("R1 heat_air after reset", int'(heat_air), 0);
        check("R1 busy after reset", int'(busy), 0);
    endtask

    // Strobe while busy is already low a second time: accepted again.
    task automatic t_back_to_back();
        run_case("R10 first", 10, 40, 1'b0, 64, 1, 4, 16, 1'b0);
        run_case("R10 second", 90, 10, 1'b0, 64, 2, 16, 32, 1'b0);
    endtask

    initial begin
        t_reset();
        run_case("R2 R5 hum half rate", 50, 40, 1'b0, 128, 1, 8, 16, 1'b0);
        run_case("R2 priority both low", 50, 10, 1'b0, 255, 1, 15, 16, 1'b0);
        run_case("R3 R6 air rate 40", 80, 20, 1'b0, 40, 2, 10, 32, 1'b0);
        run_case("R6 air clamp 128", 85, 29, 1'b0, 128, 2, 32, 32, 1'b0);
        run_case("R5 rate below 16", 0, 50, 1'b0, 15, 1, 0, 16, 1'b0);
        run_case("R4 neither low", 80, 30, 1'b0, 128, 0, 0, 5, 1'b0);
        run_case("R7 error wins", -20, -20, 1'b1, 255, 0, 0, 1, 1'b0);
        run_case("R2 signed hum", -10, 90, 1'b0, 32, 1, 2, 16, 1'b0);
        run_case("R3 signed temp", 100, -3, 1'b0, 8, 2, 2, 32, 1'b0);
        run_case("R9 disturb mid-cycle", 40, 40, 1'b0, 96, 1, 6, 16, 1'b1);
        rate = 8'd128;
        t_back_to_back();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule